// File: doc/BRIEF.md
# Ring-Chained Programmable Logic Cells

A bank of four programmable logic cells evaluates user-chosen Boolean functions with no processor involved. Each cell has a 3-input lookup table driven by two 16-way selectors and a carry bit. The selectors choose among twelve external pins and the four cell outputs. The carry bit is the raw lookup result of the neighbouring cell, and the neighbours form a closed ring. Each cell can send its lookup result straight to its output. It can also hold the result in a flip-flop, which captures on one of four events: every system clock edge, a rising edge of the cell's A selector, a rising edge of its carry input, or never.

Software programs the cells through an address/data/write-enable port. The lookup is evaluated in a way that always settles. A feedback path that does not settle, such as an inverting cell that reads its own output with no flip-flop in the path, raises a flag and does not hang the logic.

Top module: `cfg_lut_ring`

## Requirements
- R1: When `rst_n` is low, every flip-flop and every configuration field clears at once. While it is low, and after it is released with no writes, `cell_out` is 0 and `loop_flag` is 0.
- R2: The lookup index is {A,B,C}, with A as bit 2 and C as bit 0. The result is bit index of the function code. So code 8'hF0 yields A, 8'hCC yields B and 8'hAA yields C.
- R3: A select value s in 0..11 picks `pin_in[s]`. A value s in 12..15 picks `cell_out[s-12]`.
- R4: The carry input of cell i is the lookup result of cell i-1. Cell 0 takes the result of cell 3.
- R5: `wr_addr[3:2]` picks the cell and `wr_addr[1:0]` picks the field: 0 is the function code, 1 is the A select (data bits 3:0), 2 is the B select (data bits 3:0), and 3 is the cell setup (bit 0 bypass, bits 2:1 clock source). A write is applied at the clock edge where `wr_en` is high, so it affects outputs only after that edge.
- R6: With bypass set, `cell_out[i]` follows the lookup result in the same cycle. With bypass clear, `cell_out[i]` is the flip-flop value.
- R7: Clock source 0 makes the flip-flop load the lookup result on every system clock edge.
- R8: Clock source 1 loads the flip-flop on the first system edge after the A selector output rises. Clock source 2 does the same for the carry input. While that source stays high, the flip-flop holds.
- R9: Clock source 3 holds the flip-flop whatever its inputs do.
- R10: `loop_flag` is 1 when the cell outputs would still change after four evaluation passes that start from all-zero lookup results. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 4 | Cell (bits 3:2) and field (bits 1:0) |
| wr_data | input | 8 | Value to write |
| pin_in | input | 12 | External pin inputs |
| cell_out | output | 4 | Per-cell outputs |
| loop_flag | output | 1 | Feedback has not settled |

## Verification
The assertions assume that reset is held low across the first clock edge. They also assume that the pin-passing check only applies when the lookup has settled, so that check is gated by `loop_flag`. The alternate clock sources are sampled by the system clock, so the bench holds every pin value for at least one full cycle and changes pins only at the falling edge. Bench configurations are loop-free except for one deliberate inverting self-loop, which exercises the flag.

// File: rtl/cfg_lut_ring.sv
module cfg_lut_ring #(
  parameter int NCELL = 4,
  parameter int SELW  = 4,
  parameter int DW    = 8,
  localparam int NSRC = 1 << SELW,
  localparam int NPIN = NSRC - NCELL,
  localparam int CW   = $clog2(NCELL),
  localparam int AW   = CW + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [NPIN-1:0] pin_in,
  output logic [NCELL-1:0] cell_out,
  output logic            loop_flag
);

  logic [7:0]      fn   [NCELL];
  logic [SELW-1:0] asel [NCELL];
  logic [SELW-1:0] bsel [NCELL];
  logic [1:0]      cks  [NCELL];
  logic [NCELL-1:0] byp;

  logic [NCELL-1:0] q, sp, lut, a_val, c_val, src, cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byp <= '0;
      for (int i = 0; i < NCELL; i++) begin
        fn[i]   <= '0;
        asel[i] <= '0;
        bsel[i] <= '0;
        cks[i]  <= '0;
      end
    end else if (wr_en) begin
      for (int i = 0; i < NCELL; i++) begin
        if (wr_addr[AW-1:2] == CW'(i)) begin
          case (wr_addr[1:0])
            2'd0: fn[i]   <= wr_data[7:0];
            2'd1: asel[i] <= wr_data[SELW-1:0];
            2'd2: bsel[i] <= wr_data[SELW-1:0];
            default: begin
              byp[i] <= wr_data[0];
              cks[i] <= wr_data[2:1];
            end
          endcase
        end
      end
    end
  end

  // Jacobi passes from an all-zero guess; one extra pass tests for settling.
  always_comb begin
    logic [NCELL-1:0] l_cur, l_nxt, o_cur;
    logic [NSRC-1:0]  sv;
    l_cur = '0;
    l_nxt = '0;
    a_val = '0;
    for (int p = 0; p <= NCELL; p++) begin
      o_cur = (byp & l_cur) | (~byp & q);
      sv = {o_cur, pin_in};
      for (int i = 0; i < NCELL; i++) begin
        a_val[i] = sv[asel[i]];
        l_nxt[i] = fn[i][{sv[asel[i]], sv[bsel[i]], l_cur[(i + NCELL - 1) % NCELL]}];
      end
      if (p < NCELL) l_cur = l_nxt;
    end
    lut = l_cur;
    loop_flag = |(l_nxt ^ l_cur);
  end

  always_comb begin
    for (int i = 0; i < NCELL; i++) begin
      c_val[i] = lut[(i + NCELL - 1) % NCELL];
      case (cks[i])
        2'd0:    begin src[i] = 1'b1;     cap[i] = 1'b1; end
        2'd1:    begin src[i] = a_val[i]; cap[i] = a_val[i] & ~sp[i]; end
        2'd2:    begin src[i] = c_val[i]; cap[i] = c_val[i] & ~sp[i]; end
        default: begin src[i] = 1'b0;     cap[i] = 1'b0; end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q  <= '0;
      sp <= '0;
    end else begin
      sp <= src;
      for (int i = 0; i < NCELL; i++)
        if (cap[i]) q[i] <= lut[i];
    end
  end

  assign cell_out = (byp & lut) | (~byp & q);

  AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> (q == '0))
    else $error("reset left flops set"); // R1

  for (genvar g = 0; g < NCELL; g++) begin : g_chk
    AST_PASS_PIN_A: assert property (@(posedge clk) disable iff (!rst_n)
      (byp[g] && fn[g] == 8'hF0 && asel[g] < SELW'(NPIN) && !loop_flag) |-> (cell_out[g] == pin_in[asel[g]]))
      else $error("A pass-through mismatch"); // R2
    AST_FN_WRITE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == AW'({g, 2'b00})) |=> (fn[g] == $past(wr_data[7:0])))
      else $error("function write not applied"); // R5
    AST_SYS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (cks[g] == 2'd0) |=> (q[g] == $past(lut[g])))
      else $error("system clock capture missed"); // R7
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (cks[g] == 2'd3) |=> $stable(q[g]))
      else $error("held flop changed"); // R9
  end

endmodule

// File: tb/tb_cfg_lut_ring.sv
`timescale 1ns/1ps
module tb_cfg_lut_ring;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [11:0] pin_in = '0;
  logic [3:0] cell_out;
  logic loop_flag;
  int checks = 0, errors = 0;

  cfg_lut_ring dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
                    .wr_data(wr_data), .pin_in(pin_in), .cell_out(cell_out), .loop_flag(loop_flag));

  always #4 clk = ~clk;

  // entry: {write, addr[3:0], data[7:0], pins[11:0], expected cell_out[3:0]}
  localparam int NT = 25;
  localparam logic [28:0] TBL [NT] = '{
    {1'b1, 4'h0, 8'hC0, 12'h000, 4'h0},
    {1'b1, 4'h1, 8'h00, 12'h000, 4'h0},
    {1'b1, 4'h2, 8'h01, 12'h000, 4'h0},
    {1'b1, 4'h3, 8'h01, 12'h000, 4'h0},
    {1'b1, 4'h4, 8'h5A, 12'h000, 4'h0},
    {1'b1, 4'h5, 8'h02, 12'h000, 4'h0},
    {1'b1, 4'h7, 8'h01, 12'h000, 4'h0},
    {1'b1, 4'h8, 8'hFC, 12'h000, 4'h0},
    {1'b1, 4'h9, 8'h0D, 12'h000, 4'h0},
    {1'b1, 4'hA, 8'h04, 12'h000, 4'h0},
    {1'b1, 4'hB, 8'h01, 12'h000, 4'h0},
    {1'b1, 4'hC, 8'hCC, 12'h000, 4'h0},
    {1'b1, 4'hD, 8'h05, 12'h000, 4'h0},
    {1'b1, 4'hE, 8'h06, 12'h000, 4'h0},
    {1'b1, 4'hF, 8'h01, 12'h000, 4'h0},
    {1'b0, 4'h0, 8'h00, 12'h000, 4'h0},
    {1'b0, 4'h0, 8'h00, 12'h003, 4'h7},
    {1'b0, 4'h0, 8'h00, 12'h007, 4'h1},
    {1'b0, 4'h0, 8'h00, 12'h014, 4'h6},
    {1'b0, 4'h0, 8'h00, 12'h040, 4'h8},
    {1'b0, 4'h0, 8'h00, 12'h050, 4'hC},
    {1'b0, 4'h0, 8'h00, 12'hFFF, 4'hD},
    {1'b1, 4'h0, 8'hAA, 12'h000, 4'h0},
    {1'b0, 4'h0, 8'h00, 12'h040, 4'hF},
    {1'b0, 4'h0, 8'h00, 12'h044, 4'h9}
  };

  task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    #1 chk("R1 in reset", {loop_flag, cell_out}, 5'b0);
    rst_n = 1;
    @(negedge clk); #1 chk("R1 after release", {loop_flag, cell_out}, 5'b0);

    // R2 R3 R4 R5 R6: table of writes and combinational checks
    for (int k = 0; k < NT; k++) begin
      if (TBL[k][28]) wr(TBL[k][27:24], TBL[k][23:16]);
      else begin
        @(negedge clk);
        pin_in = TBL[k][15:4];
        #1 chk("R2 R3 R4 R6 table", {loop_flag, cell_out}, {1'b0, TBL[k][3:0]});
      end
    end

    // R5: write applies only after its edge
    @(negedge clk);
    pin_in = 12'h010; wr_en = 1; wr_addr = 4'h8; wr_data = 8'h00;
    #1 chk("R5 before edge", {1'b0, cell_out}, 5'b00100);
    @(negedge clk); wr_en = 0;
    #1 chk("R5 after edge", {1'b0, cell_out}, 5'b00000);

    // R7: system clock capture on cell 3
    wr(4'hF, 8'h00);
    pin_in = 12'h000;
    @(negedge clk); #1 chk("R7 low", {4'b0, cell_out[3]}, 5'd0);
    pin_in = 12'h040;
    #1 chk("R7 not yet", {4'b0, cell_out[3]}, 5'd0);
    @(negedge clk); #1 chk("R7 captured", {4'b0, cell_out[3]}, 5'd1);

    // R9: hold source
    wr(4'hF, 8'h06);
    pin_in = 12'h000;
    repeat (2) @(negedge clk);
    #1 chk("R9 held", {4'b0, cell_out[3]}, 5'd1);

    // R8: A selector (pin5) as clock, data on B (pin6)
    wr(4'hF, 8'h02);
    @(negedge clk); #1 chk("R8 no edge", {4'b0, cell_out[3]}, 5'd1);
    pin_in = 12'h020;
    #1 chk("R8 before edge", {4'b0, cell_out[3]}, 5'd1);
    @(negedge clk); #1 chk("R8 rising A", {4'b0, cell_out[3]}, 5'd0);
    pin_in = 12'h060;
    repeat (2) @(negedge clk);
    #1 chk("R8 A stays high", {4'b0, cell_out[3]}, 5'd0);

    // R10: inverting self-loop on cell 0
    wr(4'h0, 8'h0F);
    wr(4'h1, 8'h0C);
    #1 chk("R10 loop flagged", {4'b0, loop_flag}, 5'd1);
    wr(4'h0, 8'hF0);
    #1 chk("R10 settled", {4'b0, loop_flag}, 5'd0);

    // R1: reset mid-run clears a set flop
    wr(4'hF, 8'h00);
    pin_in = 12'h040;
    @(negedge clk); #1 chk("R1 flop set", {4'b0, cell_out[3]}, 5'd1);
    rst_n = 0;
    #1 chk("R1 async clear", {loop_flag, cell_out}, 5'b0);
    @(negedge clk); rst_n = 1;
    @(negedge clk); #1 chk("R1 config cleared", {loop_flag, cell_out}, 5'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule